// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns the pins of one general-purpose I/O port (up to eight pins) into interrupt sources. Every pin is first brought into the local clock domain by a two-flop synchronizer. After that, a per-pin detector looks for a level or an edge, following the pin's configuration. Software sets up each pin through four configuration words: enable, mask, trigger type and polarity. It finds pending pins in a status word, normally scanning from the highest set bit down. It acknowledges edge events by writing ones to an acknowledge word.

The bus side is a plain strobe interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high and is zero at all other times. A single interrupt line reports that at least one pin has an unmasked pending event.

Top module: `pirq_port_ctrl`

## Requirements
- R1: After reset, the enable, mask, type and polarity words read 0, the status word reads 0 and `irq_out` is 0.
- R2: The configuration words sit at byte offsets 0x30 (enable), 0x34 (mask), 0x38 (type) and 0x3C (polarity). Each word reads back its low NPINS bits as written, and all bits above NPINS read 0.
- R3: Reading the acknowledge offset 0x4C (write-only) or any unmapped offset such as 0x44 returns 0.
- R4: A pin with type bit 0 is level-sensitive. Its status bit (status word at 0x40, bit i for pin i) is 1 exactly while the synchronized pin equals its polarity bit. Writes to the acknowledge word have no effect on it.
- R5: A pin with type bit 1 and polarity bit 1 latches a pending event on a 0-to-1 transition of the synchronized pin. The event remains pending after the pin returns low.
- R6: A pin with type bit 1 and polarity bit 0 latches a pending event on a 1-to-0 transition.
- R7: Writing 1 to bit i of the acknowledge word clears pin i's pending edge event. Bits written as 0 leave their pins unchanged.
- R8: When a new qualifying edge and an acknowledge of the same pin fall on the same clock edge, the event stays pending.
- R9: A mask bit of 1 hides that pin from the status word and from `irq_out`, but does not discard its event. Clearing the mask shows the event again.
- R10: A pin whose enable bit is 0 never shows status, and any edge event it had latched is discarded.
- R11: `irq_out` is 1 exactly when any status bit is 1.
- R12: A pin change appears in the status word on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous port pins |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, zero when not reading |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two functions can land on the same clock edge: the detector recognising a fresh qualifying edge on a pin, and software acknowledging that pin's earlier event. The bench creates this collision by re-raising a pin whose event is already pending. It then times the acknowledge write so that it is captured on the exact clock edge where the synchronized edge is seen, which is the third edge after the pin change. The event must survive that edge, and a second, lone acknowledge must then clear it.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef logic [7:0] ofs_t;

  localparam ofs_t OFS_ENABLE = 8'h30;
  localparam ofs_t OFS_MASK   = 8'h34;
  localparam ofs_t OFS_TYPE   = 8'h38;
  localparam ofs_t OFS_POL    = 8'h3C;
  localparam ofs_t OFS_STATUS = 8'h40;
  localparam ofs_t OFS_ACK    = 8'h4C;

  // edge qualifier: pol=1 rising, pol=0 falling
  function automatic logic edge_match(input logic cur, input logic prv, input logic pol);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // level qualifier: pin equals polarity
  function automatic logic level_match(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  ofs_t             addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] status_i,
  output logic [DW-1:0]    rdata,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] type_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] ack_o
);
  localparam int PADW = DW - NPINS;

  logic [NPINS-1:0] en_q, mask_q, type_q, pol_q;
  logic [NPINS-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENABLE: en_q   <= wdata[NPINS-1:0];
        OFS_MASK:   mask_q <= wdata[NPINS-1:0];
        OFS_TYPE:   type_q <= wdata[NPINS-1:0];
        OFS_POL:    pol_q  <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_ENABLE: sel = en_q;
      OFS_MASK:   sel = mask_q;
      OFS_TYPE:   sel = type_q;
      OFS_POL:    sel = pol_q;
      OFS_STATUS: sel = status_i;
      default:    sel = '0;
    endcase
  end

  assign rdata  = rd_en ? {{PADW{1'b0}}, sel} : '0;
  assign ack_o  = (wr_en && addr == OFS_ACK) ? wdata[NPINS-1:0] : '0;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign type_o = type_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
  import pirq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_s,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] typ,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] pend_o,
  output logic [NPINS-1:0] edge_hit_o,
  output logic [NPINS-1:0] lvl_hit_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign edge_hit_o[i] = edge_match(pin_s[i], prev_q[i], pol[i]);
    assign lvl_hit_o[i]  = level_match(pin_s[i], pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (!en[i])   pend_q[i] <= 1'b0;
      else if (!typ[i])  pend_q[i] <= lvl_hit_o[i];
      else               pend_q[i] <= edge_hit_o[i] | (pend_q[i] & ~ack[i]);
    end

    a_r10_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !pend_q[i]);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && typ[i] && ack[i] && !edge_hit_o[i] |=> !pend_q[i]);
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && typ[i] && edge_hit_o[i] |=> pend_q[i]);
    a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && typ[i] && pend_q[i] && !ack[i] |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pirq_port_ctrl.sv
module pirq_port_ctrl
  import pirq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_out
);
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] en_w, mask_w, type_w, pol_w, ack_w;
  logic [NPINS-1:0] pend_w, edge_hit_w, lvl_hit_w;
  logic [NPINS-1:0] status_w;

  pirq_sync #(.W(NPINS)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pin_in), .q (pin_s)
  );

  pirq_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk (clk), .rst_n (rst_n), .wr_en (bus_wr), .rd_en (bus_rd),
    .addr (bus_addr), .wdata (bus_wdata), .status_i (status_w),
    .rdata (bus_rdata), .en_o (en_w), .mask_o (mask_w),
    .type_o (type_w), .pol_o (pol_w), .ack_o (ack_w)
  );

  pirq_detect #(.NPINS(NPINS)) u_detect (
    .clk (clk), .rst_n (rst_n), .pin_s (pin_s), .en (en_w),
    .typ (type_w), .pol (pol_w), .ack (ack_w), .pend_o (pend_w),
    .edge_hit_o (edge_hit_w), .lvl_hit_o (lvl_hit_w)
  );

  assign status_w = pend_w & ~mask_w;
  assign irq_out  = |status_w;
endmodule

// File: tb/pirq_port_ctrl_bench.sv
module pirq_port_ctrl_bench;
  localparam int NPINS = 8;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic             irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // {pins, expected status} for level mode, pol = 0xA5, all enabled, none masked
  localparam logic [15:0] LVL_VEC [6] = '{
    16'h005A, 16'hFFA5, 16'hA5FF, 16'h5A00, 16'h0F55, 16'hF0AA
  };

  pirq_port_ctrl #(.NPINS(NPINS), .DW(DW)) u_pirq_port_ctrl (
    .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq_out (irq_out)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [NPINS-1:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(posedge clk);
  endtask

  task automatic chk_status(input string tag, input logic [7:0] exp);
    logic [31:0] v;
    rd(8'h40, v);
    check(tag, v, {24'h0, exp});
    check({tag, " irq"}, {31'h0, irq_out}, {31'h0, |exp});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h30, v); check("R1 enable", v, 0);
    rd(8'h34, v); check("R1 mask", v, 0);
    rd(8'h38, v); check("R1 type", v, 0);
    rd(8'h3C, v); check("R1 pol", v, 0);
    chk_status("R1 status", 8'h00);

    // R2 readback, R3 write-only / unmapped
    wr(8'h3C, 32'hFFFF_FFA5); rd(8'h3C, v); check("R2 pol", v, 32'hA5);
    wr(8'h34, 32'h0000_0133); rd(8'h34, v); check("R2 mask", v, 32'h33);
    wr(8'h34, 32'h0);
    rd(8'h4C, v); check("R3 ack reads 0", v, 0);
    rd(8'h44, v); check("R3 unmapped reads 0", v, 0);

    // R4 level mode table (type = 0)
    wr(8'h30, 32'hFF);
    for (int k = 0; k < 6; k++) begin
      set_pins(LVL_VEC[k][15:8]);
      chk_status("R4 level vector", LVL_VEC[k][7:0]);
    end

    // R12 latency: pin0 goes high (pol bit0 = 1)
    @(negedge clk); pin_in = 8'hF1;
    repeat (2) @(posedge clk);
    rd(8'h40, v); check("R12 not after 2 edges", v, 32'hAA);
    rd(8'h40, v); check("R12 after 3 edges", v, 32'hAB);
    // R4 ack ignored in level mode
    wr(8'h4C, 32'hFF);
    chk_status("R4 ack ignored", 8'hAB);

    // Edge mode: low nibble rising, high nibble falling
    wr(8'h30, 32'h00);
    wr(8'h38, 32'hFF);
    wr(8'h3C, 32'h0F);
    set_pins(8'hF0);
    @(negedge clk);
    wr(8'h30, 32'hFF);
    repeat (3) @(posedge clk);
    chk_status("R10 no event while disabled", 8'h00);

    set_pins(8'hF1); chk_status("R5 rising latched", 8'h01);
    set_pins(8'hF0); chk_status("R5 held after pin low", 8'h01);
    set_pins(8'h70); chk_status("R6 falling latched", 8'h81);
    wr(8'h4C, 32'h01); chk_status("R7 ack one bit", 8'h80);
    wr(8'h4C, 32'h80); chk_status("R11 all cleared", 8'h00);

    // R9 mask keeps event
    wr(8'h34, 32'h02);
    set_pins(8'h72); chk_status("R9 masked hidden", 8'h00);
    wr(8'h34, 32'h00); chk_status("R9 unmask shows", 8'h02);
    wr(8'h4C, 32'h02); chk_status("R7 ack pin1", 8'h00);

    // R10 disable discards
    set_pins(8'h76); chk_status("R10 pin2 latched", 8'h04);
    wr(8'h30, 32'hFB); rd(8'h40, v); check("R10 disabled no status", v, 0);
    wr(8'h30, 32'hFF); rd(8'h40, v); check("R10 event discarded", v, 0);

    // R8 new edge coincides with ack
    set_pins(8'h7E); chk_status("R8 pin3 latched", 8'h08);
    set_pins(8'h76); chk_status("R8 pin3 low, held", 8'h08);
    @(negedge clk); pin_in = 8'h7E;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h08;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk_status("R8 edge wins over ack", 8'h08);
    wr(8'h4C, 32'h08); chk_status("R7 lone ack clears", 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule